// File: doc/BRIEF.md
# Dual Masked Alarm and Interrupt Router

This block sits beside a BCD clock/calendar. On each once-per-second update pulse it compares the current time against two programmable alarms. The first alarm has four fields: seconds, minutes, hours and a day-or-date field. The second alarm has three fields: minutes, hours and day-or-date, and it only ever fires on second 00. Every alarm field carries its own mask bit, so software can choose how often an alarm repeats: every second, every minute, or at a given time of day, weekday or date.

A match raises a sticky flag for that alarm. Each flag stays set until software writes a zero to it. Two active-low request lines leave the block, and one routing bit decides how they are used. In split mode each alarm has its own line. In shared mode both alarms drive line A, and line B carries a square wave chosen from four clock taps by a 2-bit rate code.

The bus interface, the timekeeping counters, the control register storage and the open-drain pads are all outside this block.

Top module: `alarm_irq_router`

## Requirements
- R1: The first alarm compares four fields: seconds, minutes, hours and day-or-date. In each 8-bit alarm field, bit 7 set removes that field from the comparison. An unmasked seconds or minutes field must equal the clock field in bits 6:0. The alarm hits when every unmasked field matches, so with all four masks set it hits on every update.
- R2: The second alarm compares minutes, hours and day-or-date, and it also requires the clock seconds to be 00. With all three of its masks set, it hits once per minute, on second 00.
- R3: Bit 6 of an alarm's day-or-date field selects the comparison: 0 compares bits 5:0 with the day of month, and 1 compares them with the day of week.
- R4: The hours field is compared on bits 6:0 exactly as stored, including the 12/24-hour mode bit (bit 6) and the AM/PM bit (bit 5). An alarm stored in a different hour mode from the clock therefore never matches.
- R5: Alarms are evaluated only in a cycle where the update pulse is high. A match found in that cycle sets the flag at that clock edge. With the pulse low, a matching time sets nothing.
- R6: A flag stays at 1 until a flag write carries 0 in its bit (bit 0 for alarm 1, bit 1 for alarm 2). Writing 1 leaves the flag unchanged. If a set and a clear fall in the same cycle, the set wins.
- R7: With the routing bit at 1, line A is low exactly when flag 1 and enable 1 are both set, and line B is low exactly when flag 2 and enable 2 are both set.
- R8: With the routing bit at 0, line A is low when either alarm has both its flag and its enable set. Line B follows the clock tap picked by the rate code: 00 picks tap 0 (1 Hz), 01 picks tap 1 (4.096 kHz), 10 picks tap 2 (8.192 kHz) and 11 picks tap 3 (32.768 kHz).
- R9: After a synchronous reset both flags are 0, so neither line is pulled low by an alarm.
- R10: An alarm whose enable is 0 never drives a line low, although its flag still sets and can still be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Once-per-second update pulse, one cycle wide |
| cur_sec | input | 8 | Clock seconds, BCD |
| cur_min | input | 8 | Clock minutes, BCD |
| cur_hour | input | 8 | Clock hours, with the mode bit in bit 6 and the AM/PM bit in bit 5 |
| cur_wday | input | 8 | Clock day of week |
| cur_mday | input | 8 | Clock day of month, BCD |
| a1_sec | input | 8 | Alarm 1 seconds; bit 7 is the mask |
| a1_min | input | 8 | Alarm 1 minutes; bit 7 is the mask |
| a1_hour | input | 8 | Alarm 1 hours; bit 7 is the mask |
| a1_dsel | input | 8 | Alarm 1 day-or-date; bit 7 is the mask, bit 6 selects weekday |
| a2_min | input | 8 | Alarm 2 minutes; bit 7 is the mask |
| a2_hour | input | 8 | Alarm 2 hours; bit 7 is the mask |
| a2_dsel | input | 8 | Alarm 2 day-or-date; bit 7 is the mask, bit 6 selects weekday |
| route_sel | input | 1 | 1 gives each alarm its own line; 0 shares line A and puts the square wave on line B |
| rate_sel | input | 2 | Square-wave tap select |
| irq_en | input | 2 | Per-alarm enable (bit 0 for alarm 1, bit 1 for alarm 2) |
| taps | input | 4 | Divided clock taps, slowest first |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data; a 0 clears, a 1 keeps |
| flags | output | 2 | Sticky alarm flags |
| irq_a_n | output | 1 | Active-low request line A |
| irq_b_n | output | 1 | Active-low request line B or square wave |

## Verification
The assertions check the flag rules on every cycle: a flag can rise only on an update pulse with a hit, a hit always sets the flag, and a flag changes only through a set or a zero write. They also check that the lines can go low only under a set flag with its enable, and that the square wave follows the selected tap in shared mode. The field matching cannot be judged cycle by cycle, so it is shown only by the bench's scenarios. These cover the mask combinations, weekday against date selection, hour-mode mismatches and second-00 gating of the second alarm.

// File: rtl/alarm_pkg.sv
// Shared widths, field positions and types for the alarm block.
// Assumes 8-bit BCD register fields, with the mask in the top bit.
package alarm_pkg;
    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 4;
    localparam int NUM_ALARMS = 2;
    localparam int NUM_TAPS   = 4;
    localparam int RATE_W     = $clog2(NUM_TAPS);

    localparam int MASK_BIT   = FIELD_W - 1;
    localparam int WDAY_BIT   = FIELD_W - 2;
    localparam int DD_VAL_W   = FIELD_W - 2;

    localparam int FLD_SEC    = 0;
    localparam int FLD_MIN    = 1;
    localparam int FLD_HOUR   = 2;
    localparam int FLD_DD     = 3;

    typedef logic [FIELD_W-1:0] field_t;
    typedef field_t [NUM_FIELDS-1:0] field_set_t;
endpackage

// File: rtl/alarm_match.sv
// Masked comparison of one alarm against the current time.
// Assumes clock fields carry 0 in the mask bit position. The hours
// field is compared with its mode bits as stored. The day-or-date
// field compares its low bits with either the weekday or the date.
module alarm_match
    import alarm_pkg::*;
(
    input  field_t     cur_sec,
    input  field_t     cur_min,
    input  field_t     cur_hour,
    input  field_t     cur_wday,
    input  field_t     cur_mday,
    input  field_set_t alm,
    output logic       hit
);
    field_set_t              opnd;
    logic [NUM_FIELDS-1:0]   fld_ok;

    // Gather the clock operand for each field, choosing weekday or date.
    always_comb begin
        opnd[FLD_SEC]  = cur_sec;
        opnd[FLD_MIN]  = cur_min;
        opnd[FLD_HOUR] = cur_hour;
        opnd[FLD_DD]   = alm[FLD_DD][WDAY_BIT] ? cur_wday : cur_mday;
    end

    // One comparator per field; a set mask bit forces that field true.
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
        if (g == FLD_DD) begin : g_dd
            assign fld_ok[g] = alm[g][MASK_BIT]
                             | (alm[g][DD_VAL_W-1:0] == opnd[g][DD_VAL_W-1:0]);
        end else begin : g_tm
            assign fld_ok[g] = alm[g][MASK_BIT]
                             | (alm[g][MASK_BIT-1:0] == opnd[g][MASK_BIT-1:0]);
        end
    end

    // The alarm hits only when every field agrees.
    assign hit = &fld_ok;
endmodule

// File: rtl/alarm_flag.sv
// Sticky flag for one alarm.
// Set on an update pulse with a hit; cleared by a write of 0; a write
// of 1 has no effect. A set wins over a clear in the same cycle.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clr_wr,
    input  logic clr_val,
    output logic flag
);
    logic set_req;
    logic clr_req;

    assign set_req = tick & hit;
    assign clr_req = clr_wr & ~clr_val;

    // Flag register: reset low, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && hit |=> flag); // R6
    AST_NO_SET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !tick |=> !flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(clr_wr && !clr_val) |=> flag); // R6
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !clr_val && !(tick && hit) |=> !flag); // R6
    AST_RESET_LOW: assert property (@(posedge clk)
        $rose(rst_n) |-> !flag); // R9
endmodule

// File: rtl/irq_router.sv
// Routes the alarm requests and the square-wave tap onto two active-low lines.
// Assumes taps are already divided clocks, so the selected tap drives line B
// directly in shared mode.
module irq_router
    import alarm_pkg::*;
(
    input  logic                  route_sel,
    input  logic [RATE_W-1:0]     rate_sel,
    input  logic [NUM_TAPS-1:0]   taps,
    input  logic [NUM_ALARMS-1:0] flags,
    input  logic [NUM_ALARMS-1:0] irq_en,
    output logic                  irq_a_n,
    output logic                  irq_b_n
);
    logic [NUM_ALARMS-1:0] req;

    assign req = flags & irq_en;

    // Output multiplexer: split lines or shared line plus square wave.
    always_comb begin
        if (route_sel) begin
            irq_a_n = ~req[0];
            irq_b_n = ~req[1];
        end else begin
            irq_a_n = ~(|req);
            irq_b_n = taps[rate_sel];
        end
    end
endmodule

// File: rtl/alarm_irq_router.sv
// Top of the dual masked alarm block.
// Assumes tick is a single-cycle pulse aligned with stable time fields.
// Alarm 2 has no seconds register; its seconds slot is fixed at an
// unmasked 00, so it can only fire on second 00.
module alarm_irq_router
    import alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic [FIELD_W-1:0]    cur_sec,
    input  logic [FIELD_W-1:0]    cur_min,
    input  logic [FIELD_W-1:0]    cur_hour,
    input  logic [FIELD_W-1:0]    cur_wday,
    input  logic [FIELD_W-1:0]    cur_mday,
    input  logic [FIELD_W-1:0]    a1_sec,
    input  logic [FIELD_W-1:0]    a1_min,
    input  logic [FIELD_W-1:0]    a1_hour,
    input  logic [FIELD_W-1:0]    a1_dsel,
    input  logic [FIELD_W-1:0]    a2_min,
    input  logic [FIELD_W-1:0]    a2_hour,
    input  logic [FIELD_W-1:0]    a2_dsel,
    input  logic                  route_sel,
    input  logic [RATE_W-1:0]     rate_sel,
    input  logic [NUM_ALARMS-1:0] irq_en,
    input  logic [NUM_TAPS-1:0]   taps,
    input  logic                  flag_wr,
    input  logic [NUM_ALARMS-1:0] flag_wdata,
    output logic [NUM_ALARMS-1:0] flags,
    output logic                  irq_a_n,
    output logic                  irq_b_n
);
    field_set_t            alm_cfg [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] hit;

    // Pack the register fields of each alarm into field sets.
    always_comb begin
        alm_cfg[0][FLD_SEC]  = a1_sec;
        alm_cfg[0][FLD_MIN]  = a1_min;
        alm_cfg[0][FLD_HOUR] = a1_hour;
        alm_cfg[0][FLD_DD]   = a1_dsel;
        alm_cfg[1][FLD_SEC]  = '0;
        alm_cfg[1][FLD_MIN]  = a2_min;
        alm_cfg[1][FLD_HOUR] = a2_hour;
        alm_cfg[1][FLD_DD]   = a2_dsel;
    end

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        alarm_match i_match (
            .cur_sec  (cur_sec),
            .cur_min  (cur_min),
            .cur_hour (cur_hour),
            .cur_wday (cur_wday),
            .cur_mday (cur_mday),
            .alm      (alm_cfg[a]),
            .hit      (hit[a])
        );
        alarm_flag i_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .hit     (hit[a]),
            .clr_wr  (flag_wr),
            .clr_val (flag_wdata[a]),
            .flag    (flags[a])
        );
    end

    irq_router i_router (
        .route_sel (route_sel),
        .rate_sel  (rate_sel),
        .taps      (taps),
        .flags     (flags),
        .irq_en    (irq_en),
        .irq_a_n   (irq_a_n),
        .irq_b_n   (irq_b_n)
    );

    AST_A_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_a_n |-> |(flags & irq_en)); // R10
    AST_SPLIT_B_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        route_sel && !irq_b_n |-> flags[1] && irq_en[1]); // R7
    AST_SPLIT_A_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        route_sel && flags[0] && irq_en[0] |-> !irq_a_n); // R7
    AST_SHARED_A_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        !route_sel && flags[1] && irq_en[1] |-> !irq_a_n); // R8
    AST_WAVE_ON_B: assert property (@(posedge clk) disable iff (!rst_n)
        !route_sel |-> irq_b_n == taps[rate_sel]); // R8
endmodule

// File: tb/test_alarm_irq_router.sv
`timescale 1ns/1ps
module test_alarm_irq_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
    logic [7:0] cur_wday = 8'h01, cur_mday = 8'h01;
    logic [7:0] a1_sec = 8'h00, a1_min = 8'h00, a1_hour = 8'h00, a1_dsel = 8'h01;
    logic [7:0] a2_min = 8'h00, a2_hour = 8'h00, a2_dsel = 8'h01;
    logic       route_sel = 1'b1;
    logic [1:0] rate_sel = 2'b11;
    logic [1:0] irq_en = 2'b00;
    logic [3:0] taps = 4'b0000;
    logic       flag_wr = 1'b0;
    logic [1:0] flag_wdata = 2'b11;
    logic [1:0] flags;
    logic       irq_a_n, irq_b_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    alarm_irq_router i_alarm_irq_router (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_wday(cur_wday), .cur_mday(cur_mday),
        .a1_sec(a1_sec), .a1_min(a1_min), .a1_hour(a1_hour), .a1_dsel(a1_dsel),
        .a2_min(a2_min), .a2_hour(a2_hour), .a2_dsel(a2_dsel),
        .route_sel(route_sel), .rate_sel(rate_sel), .irq_en(irq_en),
        .taps(taps), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .flags(flags), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    typedef struct packed {
        logic [7:0] s, m, h, wd, md;
        logic [7:0] x1s, x1m, x1h, x1d;
        logic [7:0] x2m, x2h, x2d;
        logic [1:0] exp_flags;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{8'h56,8'h34,8'h12,8'h03,8'h15, 8'h56,8'h34,8'h12,8'h15, 8'h34,8'h12,8'h15, 2'b01, 4'd1},
        '{8'h56,8'h34,8'h12,8'h03,8'h15, 8'h57,8'h34,8'h12,8'h15, 8'h34,8'h12,8'h15, 2'b00, 4'd1},
        '{8'h56,8'h34,8'h12,8'h03,8'h15, 8'h80,8'h34,8'h12,8'h15, 8'h34,8'h12,8'h15, 2'b01, 4'd1},
        '{8'h56,8'h34,8'h12,8'h03,8'h15, 8'h80,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 2'b01, 4'd2},
        '{8'h00,8'h07,8'h09,8'h05,8'h28, 8'h30,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 2'b10, 4'd2},
        '{8'h00,8'h34,8'h12,8'h03,8'h15, 8'h30,8'h34,8'h12,8'h15, 8'h34,8'h80,8'h80, 2'b10, 4'd2},
        '{8'h00,8'h34,8'h12,8'h03,8'h15, 8'h00,8'h34,8'h12,8'h43, 8'h34,8'h12,8'h43, 2'b11, 4'd3},
        '{8'h00,8'h34,8'h12,8'h03,8'h15, 8'h00,8'h34,8'h12,8'h45, 8'h34,8'h12,8'h03, 2'b00, 4'd3},
        '{8'h00,8'h34,8'h52,8'h03,8'h15, 8'h00,8'h34,8'h12,8'h15, 8'h34,8'h52,8'h15, 2'b10, 4'd4},
        '{8'h00,8'h34,8'h72,8'h03,8'h15, 8'h00,8'h34,8'h72,8'h15, 8'h34,8'h52,8'h15, 2'b01, 4'd4}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cur_sec = v.s; cur_min = v.m; cur_hour = v.h; cur_wday = v.wd; cur_mday = v.md;
        a1_sec = v.x1s; a1_min = v.x1m; a1_hour = v.x1h; a1_dsel = v.x1d;
        a2_min = v.x2m; a2_hour = v.x2h; a2_dsel = v.x2d;
    endtask

    task automatic clear_flags(input logic [1:0] wd);
        @(negedge clk); flag_wr = 1'b1; flag_wdata = wd;
        @(negedge clk); flag_wr = 1'b0; flag_wdata = 2'b11;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state: flags clear, both split lines idle high (R9).
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "flags after reset", {6'b0, flags}, 8'h00);
        chk("R9", "line A after reset", {7'b0, irq_a_n}, 8'h01);
        chk("R9", "line B after reset", {7'b0, irq_b_n}, 8'h01);

        // Table walk of the match rules (R1..R4).
        for (int i = 0; i < NV; i++) begin
            clear_flags(2'b00);
            @(negedge clk); apply(VEC[i]);
            pulse_tick();
            chk(req_name(VEC[i].req), $sformatf("vector %0d flags", i),
                {6'b0, flags}, {6'b0, VEC[i].exp_flags});
        end

        // R5: a match without the update pulse sets nothing.
        clear_flags(2'b00);
        @(negedge clk); apply(VEC[6]);
        repeat (3) @(negedge clk);
        chk("R5", "no pulse no flag", {6'b0, flags}, 8'h00);
        pulse_tick();
        chk("R5", "pulse sets flags", {6'b0, flags}, 8'h03);

        // R6: flags are sticky; a later non-matching pulse keeps them.
        @(negedge clk); a1_sec = 8'h59; a2_min = 8'h59;
        pulse_tick();
        chk("R6", "sticky over miss", {6'b0, flags}, 8'h03);
        clear_flags(2'b11);
        chk("R6", "write ones keeps", {6'b0, flags}, 8'h03);
        clear_flags(2'b10);
        chk("R6", "clear alarm 1 only", {6'b0, flags}, 8'h02);
        clear_flags(2'b00);
        chk("R6", "clear both", {6'b0, flags}, 8'h00);
        @(negedge clk); apply(VEC[6]);
        @(negedge clk); tick = 1'b1; flag_wr = 1'b1; flag_wdata = 2'b00;
        @(negedge clk); tick = 1'b0; flag_wr = 1'b0; flag_wdata = 2'b11;
        chk("R6", "set beats clear", {6'b0, flags}, 8'h03);

        // R7: split routing, each alarm on its own line.
        route_sel = 1'b1; irq_en = 2'b01; #1;
        chk("R7", "split A low", {7'b0, irq_a_n}, 8'h00);
        chk("R7", "split B high", {7'b0, irq_b_n}, 8'h01);
        irq_en = 2'b10; #1;
        chk("R7", "split A high", {7'b0, irq_a_n}, 8'h01);
        chk("R7", "split B low", {7'b0, irq_b_n}, 8'h00);

        // R10: disabled alarms keep lines high while flags stay set.
        irq_en = 2'b00; #1;
        chk("R10", "A high when disabled", {7'b0, irq_a_n}, 8'h01);
        chk("R10", "B high when disabled", {7'b0, irq_b_n}, 8'h01);
        chk("R10", "flags still set", {6'b0, flags}, 8'h03);

        // R8: shared routing and square-wave tap selection.
        route_sel = 1'b0; irq_en = 2'b10; #1;
        chk("R8", "shared A from alarm 2", {7'b0, irq_a_n}, 8'h00);
        irq_en = 2'b00; #1;
        chk("R8", "shared A idle", {7'b0, irq_a_n}, 8'h01);
        for (int r = 0; r < 4; r++) begin
            rate_sel = 2'(r);
            taps = 4'(1 << r); #1;
            chk("R8", $sformatf("tap %0d high", r), {7'b0, irq_b_n}, 8'h01);
            taps = ~4'(1 << r); #1;
            chk("R8", $sformatf("tap %0d low", r), {7'b0, irq_b_n}, 8'h00);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule